// File: doc/BRIEF.md
# Command ring decode sequencer

This block walks a command ring held in memory and hands its packets out one at a time. The ring is described by a base address, a byte read pointer and a byte write pointer. Software rings a doorbell that carries a dword index. The sequencer turns that index into a byte write pointer and, if it was idle, starts decoding. For each packet it fetches one 32-bit header and splits it into an opcode and a dword count. It then does one of two things with the body: it skips it, or it passes the body address and the header to an external opcode handler and waits for that handler's done pulse. Either way it moves the read pointer past the packet.

Two packet kinds redirect fetching into a secondary indirect buffer that has its own base, read pointer and write pointer. Once that buffer is drained, fetching returns to the ring on its own. A write-data packet's handler supplies an address, a data word and a confirm flag, and the sequencer issues the memory write itself. When the confirm flag is set, decode of the next packet waits until that write has been acknowledged.

Top module: `cmd_ring_seq`

## Requirements
- R1: After synchronous reset, `busy`, `rd_req`, `wr_req`, `hnd_req`, `in_indirect` and `tlb_inv` are all low, and the ring and indirect pointers are zero.
- R2: A doorbell with index N in the idle state sets the ring write pointer to N*4 bytes and raises `busy`. The first header read goes to `ring_base` plus the ring read pointer.
- R3: Decoding continues while the active read pointer is below the active write pointer (unsigned compare). On the ring, reaching or passing the write pointer returns the block to idle with `busy` low, and it issues no request while idle.
- R4: Header layout is type in bits [31:30], count in bits [29:16] and opcode in bits [15:8]. A no-op (opcode 0x10) with a count other than 0x3FFF moves the read pointer on by 4+(count+1)*4 bytes.
- R5: A no-op whose count is 0x3FFF sets the active read pointer equal to the active write pointer. No further header is read until a later doorbell, and that later fetch starts at the old write pointer.
- R6: An opcode outside the set {0x10, 0x21, 0x24, 0x32, 0x33, 0x40} is skipped by 4+(count+1)*4 bytes and is never offered to the handler.
- R7: Opcode 0x40 (translation-cache invalidate) drives `tlb_inv` high for exactly one cycle and is skipped like R6.
- R8: Opcodes 0x21, 0x24, 0x32 and 0x33 raise `hnd_req`, which stays high until `hnd_done`. While it is high, `hnd_header` holds the header and `hnd_addr` holds the header address plus 4. The next header is read at header address + 4 + `hnd_bytes`.
- R9: On done, opcode 0x32 sets the indirect flag, loads the indirect base from `hnd_buf_base` and sets the indirect write pointer to `hnd_buf_dw`*4, keeping the old indirect read pointer. Opcode 0x33 does the same but clears the indirect read pointer to 0.
- R10: When the indirect read pointer reaches the indirect write pointer, the indirect flag clears and fetching resumes from the ring read and write pointers.
- R11: For opcode 0x21, the sequencer writes `hnd_wr_data` to `hnd_wr_addr`. With `hnd_wr_confirm` set, no header read is issued before `wr_ack`. Without it, the next header read may overlap the pending write.
- R12: At most one read is outstanding. `rd_req` and `rd_addr` hold until `rd_ack`, `rd_req` drops right after the ack, and a read request and a handler request are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | ADDR_W | Byte base address of the ring |
| db_valid | input | 1 | Doorbell strobe |
| db_index | input | PTR_W-2 | New ring write pointer in dwords |
| rd_req | output | 1 | Header read request |
| rd_addr | output | ADDR_W | Header read byte address |
| rd_ack | input | 1 | Read complete, `rd_data` valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write complete |
| hnd_req | output | 1 | Packet offered to the handler |
| hnd_header | output | 32 | Header of the offered packet |
| hnd_addr | output | ADDR_W | Byte address of the packet body |
| hnd_done | input | 1 | Handler finished (one-cycle pulse) |
| hnd_bytes | input | PTR_W | Body bytes the handler consumed |
| hnd_buf_base | input | ADDR_W | Indirect buffer base for 0x32/0x33 |
| hnd_buf_dw | input | PTR_W-2 | Indirect buffer size in dwords |
| hnd_wr_addr | input | ADDR_W | Write address for 0x21 |
| hnd_wr_data | input | 32 | Write data for 0x21 |
| hnd_wr_confirm | input | 1 | Hold decode until the write completes |
| busy | output | 1 | Queue is being decoded |
| in_indirect | output | 1 | Fetching from the indirect buffer |
| tlb_inv | output | 1 | Invalidate pulse |

## Verification
The bench goes after five corners of this block.
- The reserved no-op count: a design that only added the count would fetch from the unused words after the jump, and the next phase would then start at the wrong ring offset.
- Indirect-buffer re-entry without a pointer clear, set against the run-list clear: mixing the two up puts the redirected fetch at base+0 where base+16 was expected, or the other way round.
- Drain back to the ring: a design that stays in the indirect buffer would hang or fetch from the indirect base.
- Confirmed writes: these are run with a slow write ack. A design that ignores the confirm flag shows a header read that overlaps the pending write, and one that always waits shows no overlap in the unconfirmed case.
- A seeded random packet stream with back-to-back doorbells: its fetch address list is compared against a bench walk of the same memory image.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam logic [7:0] OP_NOP     = 8'h10;
  localparam logic [7:0] OP_WRDATA  = 8'h21;
  localparam logic [7:0] OP_SETREG  = 8'h24;
  localparam logic [7:0] OP_IBUF    = 8'h32;
  localparam logic [7:0] OP_RUNLIST = 8'h33;
  localparam logic [7:0] OP_TLBINV  = 8'h40;
  localparam logic [13:0] CNT_TO_WPTR = 14'h3FFF;

  typedef struct packed {
    logic [1:0]  ptype;
    logic [13:0] cnt;
    logic [7:0]  op;
    logic [7:0]  rsvd;
  } hdr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_FETCH, ST_WRHOLD, ST_DISPATCH, ST_WRWAIT
  } st_e;

  function automatic logic is_handled(input logic [7:0] op);
    return (op == OP_WRDATA) || (op == OP_SETREG) ||
           (op == OP_IBUF) || (op == OP_RUNLIST);
  endfunction
endpackage

// File: rtl/crs_ptrs.sv
module crs_ptrs #(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              db_load,
  input  logic [PTR_W-1:0]  db_ptr,
  input  logic              adv_en,
  input  logic [PTR_W-1:0]  adv_bytes,
  input  logic              jump_en,
  input  logic              ib_load,
  input  logic              ib_clr,
  input  logic [ADDR_W-1:0] ib_base_in,
  input  logic [PTR_W-1:0]  ib_wptr_in,
  input  logic              ib_exit,
  output logic              in_ib,
  output logic [PTR_W-1:0]  cur_rptr,
  output logic [PTR_W-1:0]  cur_wptr,
  output logic [ADDR_W-1:0] fetch_addr
);
  logic [PTR_W-1:0]  ring_rptr, ring_wptr, ib_rptr, ib_wptr;
  logic [ADDR_W-1:0] ib_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_rptr <= '0;
      ring_wptr <= '0;
      ib_rptr   <= '0;
      ib_wptr   <= '0;
      ib_base   <= '0;
      in_ib     <= 1'b0;
    end else begin
      if (db_load) ring_wptr <= db_ptr;
      if (!in_ib) begin
        if (jump_en)     ring_rptr <= ring_wptr;
        else if (adv_en) ring_rptr <= ring_rptr + adv_bytes;
      end
      if (ib_clr) ib_rptr <= '0;
      else if (in_ib) begin
        if (jump_en)     ib_rptr <= ib_wptr;
        else if (adv_en) ib_rptr <= ib_rptr + adv_bytes;
      end
      if (ib_load) begin
        in_ib   <= 1'b1;
        ib_base <= ib_base_in;
        ib_wptr <= ib_wptr_in;
      end else if (ib_exit) begin
        in_ib <= 1'b0;
      end
    end
  end

  assign cur_rptr   = in_ib ? ib_rptr : ring_rptr;
  assign cur_wptr   = in_ib ? ib_wptr : ring_wptr;
  assign fetch_addr = (in_ib ? ib_base : ring_base) + ADDR_W'(cur_rptr);
endmodule

// File: rtl/crs_wr_chan.sv
module crs_wr_chan #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [31:0]       data_in,
  input  logic              wr_ack,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_req  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (start) begin
      wr_req  <= 1'b1;
      wr_addr <= addr_in;
      wr_data <= data_in;
    end else if (wr_ack) begin
      wr_req <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_ring_seq.sv
module cmd_ring_seq import crs_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              db_valid,
  input  logic [PTR_W-3:0]  db_index,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [31:0]       rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  input  logic              wr_ack,
  output logic              hnd_req,
  output logic [31:0]       hnd_header,
  output logic [ADDR_W-1:0] hnd_addr,
  input  logic              hnd_done,
  input  logic [PTR_W-1:0]  hnd_bytes,
  input  logic [ADDR_W-1:0] hnd_buf_base,
  input  logic [PTR_W-3:0]  hnd_buf_dw,
  input  logic [ADDR_W-1:0] hnd_wr_addr,
  input  logic [31:0]       hnd_wr_data,
  input  logic              hnd_wr_confirm,
  output logic              busy,
  output logic              in_indirect,
  output logic              tlb_inv
);
  localparam logic [PTR_W-1:0] HDR_BYTES = PTR_W'(4);

  st_e               st;
  hdr_t              hdr_in, hdr_q;
  logic [PTR_W-1:0]  cur_rptr, cur_wptr, skip_bytes, adv_bytes;
  logic [ADDR_W-1:0] fetch_addr;
  logic              more, adv_en, jump_en, ib_load, ib_clr, ib_exit, wr_start;

  assign hdr_in     = hdr_t'(rd_data);
  assign hdr_q      = hdr_t'(hnd_header);
  assign more       = cur_rptr < cur_wptr;
  assign skip_bytes = PTR_W'({hdr_in.cnt, 2'b00}) + PTR_W'(8);
  assign busy       = (st != ST_IDLE);

  crs_ptrs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_ptrs (
    .clk(clk), .rst(rst), .ring_base(ring_base),
    .db_load(db_valid), .db_ptr({db_index, 2'b00}),
    .adv_en(adv_en), .adv_bytes(adv_bytes), .jump_en(jump_en),
    .ib_load(ib_load), .ib_clr(ib_clr), .ib_base_in(hnd_buf_base),
    .ib_wptr_in({hnd_buf_dw, 2'b00}), .ib_exit(ib_exit),
    .in_ib(in_indirect), .cur_rptr(cur_rptr), .cur_wptr(cur_wptr),
    .fetch_addr(fetch_addr)
  );

  crs_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst(rst), .start(wr_start), .addr_in(hnd_wr_addr),
    .data_in(hnd_wr_data), .wr_ack(wr_ack), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Pointer commands for the current state
  always_comb begin
    adv_en    = 1'b0;
    adv_bytes = '0;
    jump_en   = 1'b0;
    ib_load   = 1'b0;
    ib_clr    = 1'b0;
    ib_exit   = 1'b0;
    wr_start  = 1'b0;
    case (st)
      ST_CHECK: ib_exit = !more && in_indirect;
      ST_FETCH: if (rd_ack) begin
        if (hdr_in.op == OP_NOP && hdr_in.cnt == CNT_TO_WPTR) begin
          jump_en = 1'b1;
        end else begin
          adv_en    = 1'b1;
          adv_bytes = is_handled(hdr_in.op) ? HDR_BYTES : skip_bytes;
        end
      end
      ST_DISPATCH: if (hnd_done) begin
        adv_en    = 1'b1;
        adv_bytes = hnd_bytes;
        ib_load   = (hdr_q.op == OP_IBUF) || (hdr_q.op == OP_RUNLIST);
        ib_clr    = (hdr_q.op == OP_RUNLIST);
        wr_start  = (hdr_q.op == OP_WRDATA);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
      hnd_req    <= 1'b0;
      hnd_header <= '0;
      hnd_addr   <= '0;
      tlb_inv    <= 1'b0;
    end else begin
      tlb_inv <= 1'b0;
      case (st)
        ST_IDLE: if (db_valid) st <= ST_CHECK;
        ST_CHECK: begin
          if (more) begin
            rd_req  <= 1'b1;
            rd_addr <= fetch_addr;
            st      <= ST_FETCH;
          end else if (!in_indirect && !db_valid) begin
            st <= ST_IDLE;
          end
        end
        ST_FETCH: if (rd_ack) begin
          rd_req <= 1'b0;
          if (is_handled(hdr_in.op)) begin
            hnd_header <= rd_data;
            hnd_addr   <= rd_addr + ADDR_W'(4);
            if (hdr_in.op == OP_WRDATA && wr_req) begin
              st <= ST_WRHOLD;
            end else begin
              hnd_req <= 1'b1;
              st      <= ST_DISPATCH;
            end
          end else begin
            tlb_inv <= (hdr_in.op == OP_TLBINV);
            st      <= ST_CHECK;
          end
        end
        ST_WRHOLD: if (!wr_req) begin
          hnd_req <= 1'b1;
          st      <= ST_DISPATCH;
        end
        ST_DISPATCH: if (hnd_done) begin
          hnd_req <= 1'b0;
          if (hdr_q.op == OP_WRDATA && hnd_wr_confirm) st <= ST_WRWAIT;
          else                                        st <= ST_CHECK;
        end
        ST_WRWAIT: if (wr_ack) st <= ST_CHECK;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crs_chk.sv
module crs_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              rd_req,
  input logic              rd_ack,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              hnd_req,
  input logic              hnd_done,
  input logic [ADDR_W-1:0] hnd_addr,
  input logic              in_indirect,
  input logic              tlb_inv
);
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> !busy && !rd_req && !hnd_req && !in_indirect && !tlb_inv);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_req && !hnd_req);

  p_inv_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    tlb_inv |=> !tlb_inv);

  p_hnd_hold_r8: assert property (@(posedge clk) disable iff (rst)
    hnd_req && !hnd_done |=> hnd_req && $stable(hnd_addr));

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  p_rd_drop_r12: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_ack |=> !rd_req);

  p_one_req_r12: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && hnd_req));
endmodule

bind cmd_ring_seq crs_chk #(.ADDR_W(ADDR_W)) u_crs_chk (
  .clk(clk), .rst(rst), .busy(busy), .rd_req(rd_req), .rd_ack(rd_ack),
  .rd_addr(rd_addr), .hnd_req(hnd_req), .hnd_done(hnd_done),
  .hnd_addr(hnd_addr), .in_indirect(in_indirect), .tlb_inv(tlb_inv)
);

// File: tb/test_cmd_ring_seq.sv
module test_cmd_ring_seq;
  localparam int ADDR_W = 32;
  localparam int PTR_W  = 20;
  localparam logic [31:0] RB = 32'h40;
  localparam logic [7:0] NOP = 8'h10, WRD = 8'h21, SETR = 8'h24,
                         IBF = 8'h32, RUNL = 8'h33, TLBI = 8'h40, BAD = 8'h5A;

  logic clk = 1'b0, rst = 1'b1;
  logic db_valid = 1'b0;
  logic [PTR_W-3:0] db_index = '0;
  logic rd_req, rd_ack = 1'b0, wr_req, wr_ack = 1'b0, hnd_req, hnd_done = 1'b0;
  logic [31:0] rd_data = '0, wr_data, hnd_header, hnd_wr_data = '0;
  logic [ADDR_W-1:0] rd_addr, wr_addr, hnd_addr, hnd_buf_base = '0, hnd_wr_addr = '0;
  logic [PTR_W-1:0] hnd_bytes = '0;
  logic [PTR_W-3:0] hnd_buf_dw = '0;
  logic hnd_wr_confirm = 1'b0, busy, in_indirect, tlb_inv;

  always #2 clk = ~clk;

  cmd_ring_seq #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) i_cmd_ring_seq (
    .clk(clk), .rst(rst), .ring_base(RB), .db_valid(db_valid), .db_index(db_index),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .hnd_req(hnd_req), .hnd_header(hnd_header), .hnd_addr(hnd_addr),
    .hnd_done(hnd_done), .hnd_bytes(hnd_bytes), .hnd_buf_base(hnd_buf_base),
    .hnd_buf_dw(hnd_buf_dw), .hnd_wr_addr(hnd_wr_addr), .hnd_wr_data(hnd_wr_data),
    .hnd_wr_confirm(hnd_wr_confirm), .busy(busy), .in_indirect(in_indirect),
    .tlb_inv(tlb_inv)
  );

  logic [31:0] mem [256];
  int n_chk = 0, n_fail = 0;
  logic [31:0] got_log [512];
  logic [31:0] exp_log [512];
  int got_n = 0, exp_n = 0, hnd_n = 0, tlb_n = 0, exp_hnd = 0, exp_tlb = 0;
  logic [31:0] hnd_addr_log [64];
  logic [7:0]  hnd_op_log [64];
  int rd_during_wr = 0, rd_hold_err = 0, wr_lat = 2;
  logic [31:0] exp_wr [16];
  int ref_rr = 0, ref_rw = 0, ref_ir = 0, ref_iw = 0;
  logic [31:0] ref_ib = '0;
  bit ref_in = 1'b0;

  function automatic logic [31:0] hdr(input logic [7:0] op, input logic [13:0] cnt);
    return {2'b11, cnt, op, 8'h00};
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] v);
    mem[a[9:2]] = v;
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Reference walk of the ring/indirect buffer, built from the requirements
  task automatic ref_run(input int w);
    int r, wp, cnt;
    logic [31:0] a, h, b0, b1, b2;
    logic [7:0] op;
    ref_rw = w;
    while (1) begin
      r  = ref_in ? ref_ir : ref_rr;
      wp = ref_in ? ref_iw : ref_rw;
      if (r < wp) begin
        a = (ref_in ? ref_ib : RB) + 32'(r);
        exp_log[exp_n] = a; exp_n++;
        h = mem[a[9:2]]; op = h[15:8]; cnt = int'(h[29:16]);
        b0 = mem[8'(a[9:2] + 8'd1)]; b1 = mem[8'(a[9:2] + 8'd2)]; b2 = mem[8'(a[9:2] + 8'd3)];
        if (op == NOP && cnt == 'h3FFF) r = wp;
        else r = r + 4 + (cnt + 1) * 4;
        if (ref_in) ref_ir = r; else ref_rr = r;
        if (op == TLBI) exp_tlb++;
        if (op == WRD || op == SETR || op == IBF || op == RUNL) exp_hnd++;
        if (op == IBF || op == RUNL) begin
          ref_in = 1'b1; ref_ib = b0; ref_iw = int'(b1[17:0]) * 4;
          if (op == RUNL) ref_ir = 0;
        end
        if (op == WRD && b0 >= 32'h3C0) exp_wr[b0[5:2]] = b1;
        if (b2 == 32'hFFFF_FFFF) exp_wr[0] = exp_wr[0];
      end else if (ref_in) ref_in = 1'b0;
      else break;
    end
  endtask

  task automatic cmp_fetch(input int from, input string req);
    check(got_n == exp_n, req, got_n, exp_n);
    for (int i = from; i < exp_n && i < got_n; i++)
      check(got_log[i] == exp_log[i], req, got_log[i], exp_log[i]);
  endtask

  task automatic doorbell(input int dw);
    @(negedge clk); db_valid = 1'b1; db_index = (PTR_W-2)'(dw);
    @(negedge clk); db_valid = 1'b0;
  endtask

  task automatic wait_idle;
    repeat (3) @(negedge clk);
    while (busy || wr_req) @(negedge clk);
  endtask

  // Memory read responder
  initial begin
    int wt; bit pend; logic [31:0] pa;
    wt = 0; pend = 1'b0; pa = '0;
    forever begin
      @(negedge clk);
      if (pend && (!rd_req || rd_addr != pa)) rd_hold_err++;
      if (rd_req && hnd_req) rd_hold_err++;
      pend = 1'b0;
      if (rd_ack) rd_ack = 1'b0;
      else if (rd_req) begin
        if (wt == 0) begin
          rd_ack = 1'b1; rd_data = mem[rd_addr[9:2]];
          got_log[got_n] = rd_addr; got_n++;
          wt = int'($urandom % 3);
        end else begin
          wt--; pend = 1'b1; pa = rd_addr;
        end
      end
    end
  end

  // Memory write responder
  initial begin
    int wc; wc = 0;
    forever begin
      @(negedge clk);
      if (wr_req && rd_req) rd_during_wr++;
      if (tlb_inv) tlb_n++;
      if (wr_ack) wr_ack = 1'b0;
      else if (wr_req) begin
        if (wc >= wr_lat) begin
          wr_ack = 1'b1; mem[wr_addr[9:2]] = wr_data; wc = 0;
        end else wc++;
      end
    end
  end

  // Opcode handler model
  initial begin
    int wt; logic [7:0] ix;
    wt = 0;
    forever begin
      @(negedge clk);
      if (hnd_done) hnd_done = 1'b0;
      else if (hnd_req) begin
        if (wt == 0) begin
          ix = hnd_addr[9:2];
          hnd_addr_log[hnd_n] = hnd_addr; hnd_op_log[hnd_n] = hnd_header[15:8];
          if (hnd_n < 63) hnd_n++;
          hnd_bytes      = PTR_W'((int'(hnd_header[29:16]) + 1) * 4);
          hnd_buf_base   = mem[ix];
          hnd_buf_dw     = mem[8'(ix + 8'd1)][PTR_W-3:0];
          hnd_wr_addr    = mem[ix];
          hnd_wr_data    = mem[8'(ix + 8'd1)];
          hnd_wr_confirm = mem[8'(ix + 8'd2)][0];
          hnd_done = 1'b1;
          wt = int'($urandom % 3);
        end else wt--;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    report;
  end

  initial begin
    int base, off, seed, k, r, c;
    logic [31:0] d;
    seed = int'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) exp_wr[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !rd_req && !wr_req && !hnd_req, "R1", {busy, rd_req, wr_req, hnd_req}, 0);
    check(!in_indirect && !tlb_inv, "R1", {in_indirect, tlb_inv}, 0);

    // Phase A: no-op skip, handled, invalidate, unsupported
    put(RB + 0, hdr(NOP, 1));
    put(RB + 12, hdr(SETR, 1));
    put(RB + 24, hdr(TLBI, 0));
    put(RB + 32, hdr(BAD, 2));
    doorbell(12);
    wait_idle;
    ref_run(48);
    cmp_fetch(0, "R4");
    check(got_log[0] == RB, "R2", got_log[0], RB);
    check(hnd_n == 1 && hnd_op_log[0] == SETR, "R6", hnd_n, 1);
    check(hnd_addr_log[0] == RB + 16, "R8", hnd_addr_log[0], RB + 16);
    check(tlb_n == 1, "R7", tlb_n, 1);
    check(!busy, "R3", busy, 0);

    // Phase B: indirect buffer, drain back to ring, jump no-op
    base = got_n;
    put(RB + 48, hdr(IBF, 1)); put(RB + 52, 32'h200); put(RB + 56, 32'd4);
    put(32'h200, hdr(NOP, 0));
    put(32'h208, hdr(TLBI, 0));
    put(RB + 60, hdr(NOP, 14'h3FFF));
    doorbell(20);
    wait_idle;
    ref_run(80);
    cmp_fetch(base, "R10");
    check(got_log[base + 1] == 32'h200, "R9", got_log[base + 1], 32'h200);
    check(got_log[base + 3] == RB + 60, "R10", got_log[base + 3], RB + 60);
    check(got_n == base + 4, "R5", got_n - base, 4);
    check(!in_indirect, "R10", in_indirect, 0);

    // Phase C: re-entry keeps indirect read pointer, run-list clears it
    base = got_n;
    put(RB + 80, hdr(IBF, 1)); put(RB + 84, 32'h200); put(RB + 88, 32'd6);
    put(32'h210, hdr(NOP, 0));
    put(RB + 92, hdr(RUNL, 1)); put(RB + 96, 32'h200); put(RB + 100, 32'd2);
    doorbell(26);
    wait_idle;
    ref_run(104);
    cmp_fetch(base, "R9");
    check(got_log[base] == RB + 80, "R5", got_log[base], RB + 80);
    check(got_log[base + 1] == 32'h210, "R9", got_log[base + 1], 32'h210);
    check(got_log[base + 3] == 32'h200, "R9", got_log[base + 3], 32'h200);

    // Phase D: confirmed write blocks the next fetch
    base = got_n; wr_lat = 12; rd_during_wr = 0;
    put(RB + 104, hdr(WRD, 2)); put(RB + 108, 32'h380);
    put(RB + 112, 32'hA5A5_0001); put(RB + 116, 32'd1);
    put(RB + 120, hdr(NOP, 0));
    doorbell(32);
    wait_idle;
    ref_run(128);
    cmp_fetch(base, "R11");
    check(rd_during_wr == 0, "R11", rd_during_wr, 0);
    check(mem[32'h380 >> 2] == 32'hA5A5_0001, "R11", mem[32'h380 >> 2], 32'hA5A5_0001);

    // Phase E: unconfirmed write lets the fetch overlap
    base = got_n; rd_during_wr = 0;
    put(RB + 128, hdr(WRD, 2)); put(RB + 132, 32'h384);
    put(RB + 136, 32'h5A5A_0002); put(RB + 140, 32'd0);
    put(RB + 144, hdr(NOP, 0));
    doorbell(38);
    wait_idle;
    ref_run(152);
    cmp_fetch(base, "R11");
    check(rd_during_wr > 0, "R11", rd_during_wr, 1);
    check(mem[32'h384 >> 2] == 32'h5A5A_0002, "R11", mem[32'h384 >> 2], 32'h5A5A_0002);

    // Random phase with back-to-back doorbells
    base = got_n; wr_lat = 2; off = 152;
    for (int b = 0; b < 8; b++) begin
      k = 1 + int'($urandom % 3);
      for (int p = 0; p < k; p++) begin
        if (off + 16 <= 440) begin
          r = int'($urandom % 5);
          c = int'($urandom % 3);
          d = 32'h3C0 + 32'(4 * ($urandom % 16));
          case (r)
            0: begin put(RB + off, hdr(NOP, 14'(c))); off += 8 + 4 * c; end
            1: begin put(RB + off, hdr(BAD, 14'(c))); off += 8 + 4 * c; end
            2: begin put(RB + off, hdr(TLBI, 14'(c % 2))); off += 8 + 4 * (c % 2); end
            3: begin put(RB + off, hdr(SETR, 14'(c))); off += 8 + 4 * c; end
            default: begin
              put(RB + off, hdr(WRD, 2)); put(RB + off + 4, d);
              put(RB + off + 8, $urandom); put(RB + off + 12, 32'($urandom % 2));
              off += 16;
            end
          endcase
        end
      end
      doorbell(off / 4);
      if (b % 2 == 1) wait_idle;
      else repeat (3) @(negedge clk);
    end
    wait_idle;
    ref_run(off);
    cmp_fetch(base, "R3");
    check(tlb_n == exp_tlb, "R7", tlb_n, exp_tlb);
    check(hnd_n == exp_hnd, "R8", hnd_n, exp_hnd);
    c = 0;
    for (int i = 0; i < 16; i++) if (mem[48 + 192 + i] != exp_wr[i]) c++;
    check(c == 0, "R11", c, 0);
    check(rd_hold_err == 0, "R12", rd_hold_err, 0);
    check(!busy && !in_indirect, "R3", {busy, in_indirect}, 0);
    if (seed == 0) $display("seeded");
    report;
  end
endmodule